// File: doc/BRIEF.md
# Interval Timer Bus Register Front End

This block sits between a narrow processor bus and three independent down-counting timer channels. The host sees four byte-wide ports selected by a two-bit address. Three of them are per-channel data ports. The fourth is a shared control port. A control byte names one channel and fixes that channel's counting mode, its number format and the order in which its divisor and count bytes move over the bus.

Divisor bytes are gathered per channel in the programmed order. The full 16-bit value is handed to the channel as a one-cycle load pulse. Count reads return either the live channel count or a snapshot taken by a latch command. Each channel keeps its own write-byte and read-byte pointers, so accesses to different channels may be interleaved freely.

The bidirectional data bus is carried as separate input, output and output-enable signals, which the pad ring combines. Bus strobes are sampled in the block clock domain. A write takes effect on the first clock where chip select and the write strobe are both low. A read counts as finished on the first clock after chip select and the read strobe stop being low together.

Top module: `tmr_host_if`

## Requirements
- R1: Address 0, 1 and 2 select the data port of channel 0, 1 and 2, and address 3 selects the control port. An access made while cs_n is high has no effect. Each low period of wr_n with cs_n low performs exactly one write.
- R2: A control byte whose bits 5:4 are non-zero configures the channel named in bits 7:6. Bit 0 goes to the number-format output, bits 3:1 go to the mode output, and bits 5:4 set the byte order: 01 is low byte only, 10 is high byte only, 11 is low byte then high byte. The configured channel's ch_cfg_o pulses for one cycle. A control byte with 11 in bits 7:6 changes nothing.
- R3: In low-only order, each data write loads the divisor {8'h00, byte} with a one-cycle ch_load_o pulse in the cycle after the write is sampled.
- R4: In high-only order, each data write loads the divisor {byte, 8'h00}.
- R5: In low-then-high order, the first data write is held without any load. The second write loads {second, first}.
- R6: A control byte resets the write-byte and read-byte pointers of the channel it configures, and of no other channel.
- R7: A control byte with 00 in bits 5:4 latches the named channel's current count. Reads then return the snapshot until it has been read completely. A further latch command issued while a snapshot is pending is ignored.
- R8: Reads return the low byte in low-only order and the high byte in high-only order. In low-then-high order, reads alternate low then high, tracked per channel.
- R9: When the final byte of a pending snapshot is read and a new latch command for that channel is written in the same cycle, a fresh snapshot is taken.
- R10: d_oe is high only while cs_n and rd_n are both low and the address selects a channel. At all other times d_out is zero.
- R11: After reset every channel reads in low-then-high order, with mode 0, binary format, no pending snapshot, and no load or configuration pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port address |
| d_in | input | 8 | Data from the bus |
| d_out | output | 8 | Data to the bus |
| d_oe | output | 1 | Bus output enable |
| ch_count_i | input | 3x16 | Live count of each channel |
| ch_load_o | output | 3 | Divisor load pulse per channel |
| ch_div_o | output | 3x16 | Divisor value per channel |
| ch_mode_o | output | 3x3 | Operating mode per channel |
| ch_bcd_o | output | 3 | Decimal-format select per channel |
| ch_cfg_o | output | 3 | Configuration pulse per channel |

## Verification
A read completes on the clock after its strobes are released, so the end of a final snapshot read can land in the same cycle as a latch command sampled from the control port. The bench provokes this by releasing rd_n and lowering wr_n with address 3 on the same edge while cs_n stays low. It then changes the live count. The next two reads must return the count present at the latch edge, not the old snapshot and not the later live value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ORD_LATCH = 2'b00,
    ORD_LO    = 2'b01,
    ORD_HI    = 2'b10,
    ORD_LOHI  = 2'b11
  } order_e;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cw_stb,
  output logic              dw_stb,
  output logic              rd_done,
  output logic [ADDR_W-1:0] rd_sel,
  output logic              rd_act
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

  logic              wr_act;
  logic              wr_act_q, wr_act_d;
  logic              rd_act_q, rd_act_d;
  logic [ADDR_W-1:0] rd_sel_q, rd_sel_d;
  logic              wr_edge;

  always_comb begin
    wr_act   = !cs_n && !wr_n;
    rd_act   = !cs_n && !rd_n && (addr != CTRL_ADDR);
    wr_edge  = wr_act && !wr_act_q;
    cw_stb   = wr_edge && (addr == CTRL_ADDR);
    dw_stb   = wr_edge && (addr != CTRL_ADDR);
    rd_done  = rd_act_q && !rd_act;
    wr_act_d = wr_act;
    rd_act_d = rd_act;
    rd_sel_d = rd_act ? addr : rd_sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      rd_sel_q <= '0;
    end else begin
      wr_act_q <= wr_act_d;
      rd_act_q <= rd_act_d;
      rd_sel_q <= rd_sel_d;
    end
  end

  assign rd_sel = rd_sel_q;

  // R1: one write per strobe low period
  p_one_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_stb || dw_stb) |=> !(cw_stb || dw_stb));
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_stb,
  input  logic              dw_stb,
  input  logic              rd_done,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  count_in,
  output logic [MODE_W-1:0] mode,
  output logic              bcd,
  output logic              cfg_stb,
  output logic              load,
  output logic [CNT_W-1:0]  divisor,
  output logic [BYTE_W-1:0] rd_byte
);
  order_e              ord_q, ord_d;
  logic [MODE_W-1:0]   mode_q, mode_d;
  logic                bcd_q, bcd_d;
  logic                cfg_q, cfg_d;
  logic                load_q, load_d;
  logic [CNT_W-1:0]    div_q, div_d;
  logic                wr_hi_q, wr_hi_d;
  logic [BYTE_W-1:0]   lo_hold_q, lo_hold_d;
  logic                rd_hi_q, rd_hi_d;
  logic                snap_v_q, snap_v_d;
  logic [CNT_W-1:0]    snap_q, snap_d;
  logic                latch_cmd, cfg_cmd, last_rd, take_snap;
  logic [CNT_W-1:0]    rd_src;

  always_comb begin
    ord_d     = ord_q;
    mode_d    = mode_q;
    bcd_d     = bcd_q;
    cfg_d     = 1'b0;
    load_d    = 1'b0;
    div_d     = div_q;
    wr_hi_d   = wr_hi_q;
    lo_hold_d = lo_hold_q;
    rd_hi_d   = rd_hi_q;
    snap_v_d  = snap_v_q;
    snap_d    = snap_q;

    latch_cmd = cw_stb && (wr_data[5:4] == ORD_LATCH);
    cfg_cmd   = cw_stb && (wr_data[5:4] != ORD_LATCH);
    last_rd   = rd_done && ((ord_q != ORD_LOHI) || rd_hi_q);
    take_snap = latch_cmd && (!snap_v_q || last_rd);

    if (cfg_cmd) begin
      ord_d    = order_e'(wr_data[5:4]);
      mode_d   = wr_data[3:1];
      bcd_d    = wr_data[0];
      cfg_d    = 1'b1;
      wr_hi_d  = 1'b0;
      rd_hi_d  = 1'b0;
      snap_v_d = 1'b0;
    end else begin
      if (dw_stb) begin
        case (ord_q)
          ORD_LO: begin
            div_d  = {{BYTE_W{1'b0}}, wr_data};
            load_d = 1'b1;
          end
          ORD_HI: begin
            div_d  = {wr_data, {BYTE_W{1'b0}}};
            load_d = 1'b1;
          end
          ORD_LOHI: begin
            if (!wr_hi_q) begin
              lo_hold_d = wr_data;
              wr_hi_d   = 1'b1;
            end else begin
              div_d   = {wr_data, lo_hold_q};
              load_d  = 1'b1;
              wr_hi_d = 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (rd_done && (ord_q == ORD_LOHI)) rd_hi_d = !rd_hi_q;
      if (last_rd) snap_v_d = 1'b0;
      if (take_snap) begin
        snap_v_d = 1'b1;
        snap_d   = count_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q     <= ORD_LOHI;
      mode_q    <= '0;
      bcd_q     <= 1'b0;
      cfg_q     <= 1'b0;
      load_q    <= 1'b0;
      div_q     <= '0;
      wr_hi_q   <= 1'b0;
      lo_hold_q <= '0;
      rd_hi_q   <= 1'b0;
      snap_v_q  <= 1'b0;
      snap_q    <= '0;
    end else begin
      ord_q     <= ord_d;
      mode_q    <= mode_d;
      bcd_q     <= bcd_d;
      cfg_q     <= cfg_d;
      load_q    <= load_d;
      div_q     <= div_d;
      wr_hi_q   <= wr_hi_d;
      lo_hold_q <= lo_hold_d;
      rd_hi_q   <= rd_hi_d;
      snap_v_q  <= snap_v_d;
      snap_q    <= snap_d;
    end
  end

  always_comb begin
    rd_src = snap_v_q ? snap_q : count_in;
    case (ord_q)
      ORD_HI:   rd_byte = rd_src[CNT_W-1:BYTE_W];
      ORD_LOHI: rd_byte = rd_hi_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
      default:  rd_byte = rd_src[BYTE_W-1:0];
    endcase
  end

  assign mode    = mode_q;
  assign bcd     = bcd_q;
  assign cfg_stb = cfg_q;
  assign load    = load_q;
  assign divisor = div_q;

  // R3: load is a single-cycle pulse
  p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q);
  // R5: a two-byte load follows a held low byte
  p_lohi_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && ord_q == ORD_LOHI) |-> $past(wr_hi_q));
  // R6: configuring clears both byte pointers
  p_ptr_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q |-> (!wr_hi_q && !rd_hi_q));
  // R8: the read pointer only advances in two-byte order
  p_rdptr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_q |-> (ord_q == ORD_LOHI));
  // R7: a pending snapshot holds still
  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_v_q && !rd_done && !cw_stb) |=> (snap_v_q && $stable(snap_q)));
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cs_n,
  input  logic                           rd_n,
  input  logic                           wr_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [BYTE_W-1:0]              d_in,
  output logic [BYTE_W-1:0]              d_out,
  output logic                           d_oe,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   ch_count_i,
  output logic [NUM_CH-1:0]              ch_load_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   ch_div_o,
  output logic [NUM_CH-1:0][MODE_W-1:0]  ch_mode_o,
  output logic [NUM_CH-1:0]              ch_bcd_o,
  output logic [NUM_CH-1:0]              ch_cfg_o
);
  localparam int SEL_LO = BYTE_W - ADDR_W;

  logic                                cw_stb, dw_stb, rd_done, rd_act;
  logic [ADDR_W-1:0]                   rd_sel;
  logic [NUM_CH-1:0][BYTE_W-1:0]       rd_byte;

  tmr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .cw_stb  (cw_stb),
    .dw_stb  (dw_stb),
    .rd_done (rd_done),
    .rd_sel  (rd_sel),
    .rd_act  (rd_act)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ch_cw, ch_dw, ch_rd;
    assign ch_cw = cw_stb  && (d_in[BYTE_W-1:SEL_LO] == ADDR_W'(g));
    assign ch_dw = dw_stb  && (addr == ADDR_W'(g));
    assign ch_rd = rd_done && (rd_sel == ADDR_W'(g));

    tmr_chan_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cw_stb   (ch_cw),
      .dw_stb   (ch_dw),
      .rd_done  (ch_rd),
      .wr_data  (d_in),
      .count_in (ch_count_i[g]),
      .mode     (ch_mode_o[g]),
      .bcd      (ch_bcd_o[g]),
      .cfg_stb  (ch_cfg_o[g]),
      .load     (ch_load_o[g]),
      .divisor  (ch_div_o[g]),
      .rd_byte  (rd_byte[g])
    );
  end

  always_comb begin
    d_out = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_act && (addr == ADDR_W'(i))) d_out = rd_byte[i];
    end
  end

  assign d_oe = rd_act;

  // R10: bus quiet unless chip selected and read strobed
  p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (!d_oe && d_out == '0));
  // R2: only one channel configures per control byte
  p_cfg_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_cfg_o));
endmodule

// File: tb/tmr_host_if_bench.sv
`timescale 1ns/1ps
module tmr_host_if_bench;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             cs_n, rd_n, wr_n;
  logic [1:0]       addr;
  logic [7:0]       d_in, d_out;
  logic             d_oe;
  logic [2:0][15:0] cnt;
  logic [2:0]       ld, bcdo, cfgo;
  logic [2:0][15:0] divo;
  logic [2:0][2:0]  modeo;

  int checks = 0;
  int fails  = 0;

  logic [2:0]       s_ld, s_cfg;
  logic [2:0][15:0] s_div;

  always #4 clk = ~clk;

  tmr_host_if u_tmr_host_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .ch_count_i(cnt), .ch_load_o(ld), .ch_div_o(divo),
    .ch_mode_o(modeo), .ch_bcd_o(bcdo), .ch_cfg_o(cfgo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic desel);
    @(negedge clk);
    cs_n = desel; addr = a; d_in = d; wr_n = 1'b0;
    @(posedge clk); #1;
    s_ld = ld; s_div = divo; s_cfg = cfgo;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic desel,
                        output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = desel; addr = a; rd_n = 1'b0;
    @(posedge clk); #1;
    d = d_out; oe = d_oe;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    @(posedge clk);
  endtask

  function automatic logic [7:0] cw(input int ch, input int ord, input int md, input int b);
    return 8'((ch << 6) | (ord << 4) | (md << 1) | b);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rb, lo, hi;
    logic       oe;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = 2'd0; d_in = 8'h00; cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R11 reset state
    chk("R11 mode", 32'(modeo), 0);
    chk("R11 bcd", 32'(bcdo), 0);
    chk("R11 load", 32'(ld), 0);
    chk("R11 cfg", 32'(cfgo), 0);
    chk("R11 oe", 32'(d_oe), 0);
    cnt[0] = 16'hA1B2;
    bus_rd(2'd0, 1'b0, lo, oe);
    bus_rd(2'd0, 1'b0, hi, oe);
    chk("R11 default two-byte read", {16'h0, hi, lo}, 32'hA1B2);

    // sweep: channel x byte order x mode
    for (int ch = 0; ch < 3; ch++) begin
      for (int ord = 1; ord < 4; ord++) begin
        for (int md = 0; md < 6; md++) begin
          logic [7:0]  v1, v2;
          logic [15:0] exp_div, c;
          int          b;
          b  = md % 2;
          v1 = 8'(ch * 53 + ord * 17 + md * 9 + 1);
          v2 = ~v1;
          bus_wr(2'd3, cw(ch, ord, md, b), 1'b0);
          chk("R2 cfg pulse", 32'(s_cfg), 32'(1 << ch));
          chk("R2 mode", 32'(modeo[ch]), 32'(md));
          chk("R2 bcd", 32'(bcdo[ch]), 32'(b));
          bus_wr(2'(ch), v1, 1'b0);
          if (ord == 1) begin
            chk("R3 load", 32'(s_ld), 32'(1 << ch));
            chk("R3 div", 32'(s_div[ch]), 32'(v1));
          end else if (ord == 2) begin
            chk("R4 load", 32'(s_ld), 32'(1 << ch));
            chk("R4 div", 32'(s_div[ch]), 32'({v1, 8'h00}));
          end else begin
            chk("R5 no load after low byte", 32'(s_ld), 0);
            bus_wr(2'(ch), v2, 1'b0);
            exp_div = {v2, v1};
            chk("R5 load", 32'(s_ld), 32'(1 << ch));
            chk("R5 div", 32'(s_div[ch]), 32'(exp_div));
          end
          c = 16'(ch * 4099 + ord * 257 + md * 31 + 7);
          cnt[ch] = c;
          bus_rd(2'(ch), 1'b0, rb, oe);
          chk("R10 oe during read", 32'(oe), 1);
          if (ord == 2) chk("R8 high byte read", 32'(rb), 32'(c[15:8]));
          else          chk("R8 low byte read", 32'(rb), 32'(c[7:0]));
          if (ord == 3) begin
            bus_rd(2'(ch), 1'b0, rb, oe);
            chk("R8 second byte read", 32'(rb), 32'(c[15:8]));
          end
        end
      end
    end

    // R1 deselected accesses ignored; R10 quiet bus
    bus_wr(2'd3, cw(0, 1, 2, 0), 1'b0);
    bus_wr(2'd0, 8'h5C, 1'b1);
    chk("R1 no load when deselected", 32'(s_ld), 0);
    bus_wr(2'd3, cw(0, 2, 4, 1), 1'b1);
    chk("R1 control ignored when deselected", 32'(modeo[0]), 2);
    bus_rd(2'd0, 1'b1, rb, oe);
    chk("R10 oe low when deselected", {23'h0, oe, rb}, 0);
    bus_rd(2'd3, 1'b0, rb, oe);
    chk("R10 oe low on control address", {23'h0, oe, rb}, 0);
    bus_wr(2'd3, cw(3, 1, 5, 1), 1'b0);
    chk("R2 select 3 no cfg", 32'(s_cfg), 0);
    chk("R2 select 3 keeps mode", 32'(modeo[0]), 2);

    // R6 interleaved sequencing
    bus_wr(2'd3, cw(0, 3, 1, 0), 1'b0);
    bus_wr(2'd3, cw(2, 3, 1, 0), 1'b0);
    bus_wr(2'd0, 8'h11, 1'b0);
    bus_wr(2'd2, 8'h22, 1'b0);
    bus_wr(2'd0, 8'h33, 1'b0);
    chk("R6 ch0 load after interleave", 32'(s_ld), 1);
    chk("R6 ch0 div", 32'(s_div[0]), 32'h3311);
    bus_wr(2'd3, cw(2, 3, 1, 0), 1'b0);
    bus_wr(2'd2, 8'h44, 1'b0);
    chk("R6 ch2 restarted at low byte", 32'(s_ld), 0);
    bus_wr(2'd2, 8'h55, 1'b0);
    chk("R6 ch2 div", 32'(s_div[2]), 32'h5544);
    cnt[1] = 16'hBEEF;
    bus_wr(2'd3, cw(1, 3, 0, 0), 1'b0);
    bus_rd(2'd1, 1'b0, rb, oe);
    bus_wr(2'd3, cw(2, 3, 0, 0), 1'b0);
    bus_rd(2'd1, 1'b0, rb, oe);
    chk("R6 ch1 read pointer kept", 32'(rb), 32'hBE);

    // R7 latch
    cnt[1] = 16'h1234;
    bus_wr(2'd3, cw(1, 0, 0, 0), 1'b0);
    chk("R7 latch does not configure", 32'(s_cfg), 0);
    cnt[1] = 16'h5678;
    bus_wr(2'd3, cw(1, 0, 0, 0), 1'b0);
    cnt[1] = 16'h9ABC;
    bus_rd(2'd1, 1'b0, lo, oe);
    bus_rd(2'd1, 1'b0, hi, oe);
    chk("R7 snapshot", {16'h0, hi, lo}, 32'h1234);
    bus_rd(2'd1, 1'b0, lo, oe);
    chk("R7 live after snapshot read", 32'(lo), 32'hBC);
    bus_rd(2'd1, 1'b0, hi, oe);

    // R9 final byte read and latch command in the same cycle
    cnt[2] = 16'hAAAA;
    bus_wr(2'd3, cw(2, 0, 0, 0), 1'b0);
    cnt[2] = 16'hCCDD;
    bus_rd(2'd2, 1'b0, lo, oe);
    chk("R9 first byte of old snapshot", 32'(lo), 32'hAA);
    @(negedge clk);
    cs_n = 1'b0; addr = 2'd2; rd_n = 1'b0;
    @(posedge clk); #1;
    chk("R9 second byte of old snapshot", 32'(d_out), 32'hAA);
    @(negedge clk);
    rd_n = 1'b1; addr = 2'd3; d_in = cw(2, 0, 0, 0); wr_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    cnt[2] = 16'h1111;
    bus_rd(2'd2, 1'b0, lo, oe);
    bus_rd(2'd2, 1'b0, hi, oe);
    chk("R9 fresh snapshot", {16'h0, hi, lo}, 32'hCCDD);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule